// File: doc/BRIEF.md
# MDIO Management Command Controller

This block lets software reach the management registers of an external Ethernet PHY over the two-wire MDIO interface, using clause-22 framing. Software sees two registers on a small strobe-based bus: a command word and a data word. A command holds the PHY address, the register number, the transfer direction and a busy flag. Writing the command with the busy flag set starts a frame. The hardware clears the flag once the frame has gone out on the wire.

For a write, software first loads the 16-bit value into the data register and then issues the command. The controller takes its copy of the data when the frame is launched. For a read, the controller releases the data line once the address has been sent. It shifts in the PHY's 16 response bits on rising MDC edges. The captured value is in the data register by the time busy reads back as zero.

MDC comes from the system clock through a parameterised divider. MDC stays low whenever no frame is in progress. MDIO leaves the block as a separate output, output-enable and input, so the tri-state buffer sits at the pad.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset the busy flag, the stored command fields and the data register all read as zero, MDC is low and the MDIO output enable is low.
- R2: Writing the command register (word address 0) with bit 0 set while idle starts a frame. Bit 0 reads back as 1 until the frame has finished and as 0 afterwards.
- R3: Every frame is 64 bits sent MSB first on MDIO, in this order: 32 ones, start pattern 01, an opcode (01 when command bit 1 is 1 for a write, 10 when bit 1 is 0 for a read), the PHY address from command bits 16:12, the register number from command bits 8:4, two turnaround bits and 16 data bits.
- R4: In a write frame the turnaround bits are 10, followed by the data register value (word address 1, bits 15:0) as it stood when the frame was launched. Later writes to the data register do not change the frame in progress.
- R5: In a read frame the output enable drops from the first turnaround bit to the end of the frame. MDIO is sampled on the 16 rising MDC edges of the data field, and when busy reads 0 the data register holds those bits, first sampled bit as bit 15.
- R6: MDC stays high for CLK_DIV system clocks and low for CLK_DIV system clocks while a frame runs. It gives exactly 64 rising edges per frame and stays low while no frame is active.
- R7: A write to the command register while busy is set is ignored: the stored fields do not change and no further frame is launched.
- R8: Writing the command register with bit 0 clear stores the direction, register and address fields without starting a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; read data is zero when low |
| bus_addr | input | 2 | Word address: 0 command, 1 data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address and strobe |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value to drive when enabled |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen at the pad |

## Verification
The bench models a PHY that records MDIO on every rising MDC edge and returns read data on falling edges. Its vectors mix both directions with all-ones and all-zero addresses and data, so a swapped opcode, a field taken from the wrong command bits or an extra shift would show up as a wrong bit in the captured frame. Reads check the exact turnaround bit at which the output enable drops. An enable released one bit late would fight the PHY; one released early would corrupt the register number. Directed cases rewrite the data register and the command mid-frame: a controller that does not snapshot its data at launch, or that accepts a command while busy, would send altered bits or a second frame. A further case checks that a command with bit 0 clear produces no MDC edges at all.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int BUS_AW      = 2;
    localparam int BUS_DW      = 32;
    localparam int MDIO_DW     = 16;
    localparam int FIELD_W     = 5;

    localparam logic [BUS_AW-1:0] ADDR_CMD  = 2'd0;
    localparam logic [BUS_AW-1:0] ADDR_DATA = 2'd1;

    localparam int CMD_GO_BIT  = 0;
    localparam int CMD_DIR_BIT = 1;
    localparam int CMD_REG_LSB = 4;
    localparam int CMD_PHY_LSB = 12;

    localparam int PRE_BITS    = 32;
    localparam int FRAME_BITS  = PRE_BITS + 2 + 2 + FIELD_W + FIELD_W + 2 + MDIO_DW;
    localparam int IDX_W       = $clog2(FRAME_BITS);
    localparam int TA_IDX      = PRE_BITS + 2 + 2 + FIELD_W + FIELD_W;
    localparam int RX_IDX      = TA_IDX + 2;

    typedef struct packed {
        logic               wr;
        logic [FIELD_W-1:0] phy;
        logic [FIELD_W-1:0] regnum;
    } cmd_t;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             mdc;
    } div_st_t;

    div_st_t div_d, div_q;
    logic    wrap;

    always_comb begin
        div_d = div_q;
        wrap  = run && (div_q.cnt == CNT_LAST);
        if (!run) begin
            div_d.cnt = '0;
            div_d.mdc = 1'b0;
        end else if (wrap) begin
            div_d.cnt = '0;
            div_d.mdc = ~div_q.mdc;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
        rise_tick = wrap && !div_q.mdc;
        fall_tick = wrap &&  div_q.mdc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign mdc = div_q.mdc;
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
    import mdio_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  cmd_t               cmd,
    input  logic [MDIO_DW-1:0] tx_data,
    input  logic               rise_tick,
    input  logic               fall_tick,
    input  logic               mdio_i,
    output logic               active,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic               cap_valid,
    output logic [MDIO_DW-1:0] cap_data
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] IDX_TA   = IDX_W'(TA_IDX);
    localparam logic [IDX_W-1:0] IDX_RX   = IDX_W'(RX_IDX);

    typedef struct packed {
        logic                  active;
        logic                  is_rd;
        logic [FRAME_BITS-1:0] sh;
        logic [IDX_W-1:0]      idx;
        logic                  o;
        logic                  oe;
        logic [MDIO_DW-1:0]    rx;
    } eng_st_t;

    eng_st_t eng_d, eng_q;
    logic [IDX_W-1:0] idx_nx;

    always_comb begin
        eng_d     = eng_q;
        cap_valid = 1'b0;
        idx_nx    = eng_q.idx + 1'b1;
        if (!eng_q.active) begin
            if (start) begin
                eng_d.active = 1'b1;
                eng_d.is_rd  = !cmd.wr;
                eng_d.sh     = {{PRE_BITS{1'b1}}, 2'b01,
                                (cmd.wr ? 2'b01 : 2'b10),
                                cmd.phy, cmd.regnum,
                                (cmd.wr ? 2'b10 : 2'b00),
                                (cmd.wr ? tx_data : {MDIO_DW{1'b0}})};
                eng_d.idx    = '0;
                eng_d.o      = 1'b1;
                eng_d.oe     = 1'b1;
                eng_d.rx     = '0;
            end
        end else begin
            if (rise_tick && eng_q.is_rd && (eng_q.idx >= IDX_RX)) begin
                eng_d.rx = {eng_q.rx[MDIO_DW-2:0], mdio_i};
            end
            if (fall_tick) begin
                if (eng_q.idx == IDX_LAST) begin
                    eng_d.active = 1'b0;
                    eng_d.o      = 1'b0;
                    eng_d.oe     = 1'b0;
                    cap_valid    = eng_q.is_rd;
                end else begin
                    eng_d.idx = idx_nx;
                    eng_d.sh  = {eng_q.sh[FRAME_BITS-2:0], 1'b0};
                    eng_d.o   = eng_q.sh[FRAME_BITS-2];
                    eng_d.oe  = !(eng_q.is_rd && (idx_nx >= IDX_TA));
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign active   = eng_q.active;
    assign mdio_o   = eng_q.o;
    assign mdio_oe  = eng_q.oe;
    assign cap_data = eng_q.rx;
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [BUS_AW-1:0]  bus_addr,
    input  logic [BUS_DW-1:0]  bus_wdata,
    output logic [BUS_DW-1:0]  bus_rdata,
    input  logic               eng_active,
    input  logic               cap_valid,
    input  logic [MDIO_DW-1:0] cap_data,
    output logic               start,
    output cmd_t               cmd,
    output logic [MDIO_DW-1:0] data,
    output logic               busy
);
    typedef struct packed {
        cmd_t               cmd;
        logic               pend;
        logic [MDIO_DW-1:0] data;
    } reg_st_t;

    reg_st_t reg_d, reg_q;
    logic    busy_now;

    always_comb begin
        reg_d    = reg_q;
        busy_now = reg_q.pend || eng_active;
        if (reg_q.pend) reg_d.pend = 1'b0;
        if (bus_wr && (bus_addr == ADDR_CMD) && !busy_now) begin
            reg_d.cmd.wr     = bus_wdata[CMD_DIR_BIT];
            reg_d.cmd.regnum = bus_wdata[CMD_REG_LSB +: FIELD_W];
            reg_d.cmd.phy    = bus_wdata[CMD_PHY_LSB +: FIELD_W];
            reg_d.pend       = bus_wdata[CMD_GO_BIT];
        end
        if (bus_wr && (bus_addr == ADDR_DATA)) begin
            reg_d.data = bus_wdata[MDIO_DW-1:0];
        end
        if (cap_valid) begin
            reg_d.data = cap_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == ADDR_CMD) begin
                bus_rdata[CMD_GO_BIT]               = busy_now;
                bus_rdata[CMD_DIR_BIT]              = reg_q.cmd.wr;
                bus_rdata[CMD_REG_LSB +: FIELD_W]   = reg_q.cmd.regnum;
                bus_rdata[CMD_PHY_LSB +: FIELD_W]   = reg_q.cmd.phy;
            end else if (bus_addr == ADDR_DATA) begin
                bus_rdata[MDIO_DW-1:0] = reg_q.data;
            end
        end
    end

    assign start = reg_q.pend;
    assign cmd   = reg_q.cmd;
    assign data  = reg_q.data;
    assign busy  = busy_now;
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
    import mdio_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic               start_w;
    cmd_t               cmd_w;
    logic [MDIO_DW-1:0] data_w;
    logic               busy_w;
    logic               active_w;
    logic               rise_w;
    logic               fall_w;
    logic               cap_valid_w;
    logic [MDIO_DW-1:0] cap_data_w;

    mdio_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .eng_active (active_w),
        .cap_valid  (cap_valid_w),
        .cap_data   (cap_data_w),
        .start      (start_w),
        .cmd        (cmd_w),
        .data       (data_w),
        .busy       (busy_w)
    );

    mdio_clkdiv #(.CLK_DIV(CLK_DIV)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (active_w),
        .mdc       (mdc),
        .rise_tick (rise_w),
        .fall_tick (fall_w)
    );

    mdio_frame_eng u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_w),
        .cmd       (cmd_w),
        .tx_data   (data_w),
        .rise_tick (rise_w),
        .fall_tick (fall_w),
        .mdio_i    (mdio_i),
        .active    (active_w),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .cap_valid (cap_valid_w),
        .cap_data  (cap_data_w)
    );
endmodule

// File: rtl/mdio_cmd_ctrl_chk.sv
module mdio_cmd_ctrl_chk
    import mdio_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mdc,
    input logic              mdio_oe,
    input logic              busy,
    input logic              bus_wr,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [BUS_DW-1:0] bus_wdata,
    input cmd_t              cmd_q
);
    logic [15:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hi_cnt <= '0;
        else if (!mdc)    hi_cnt <= '0;
        else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
    end

    logic cmd_wr;
    assign cmd_wr = bus_wr && (bus_addr == ADDR_CMD);

    p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && bus_wdata[CMD_GO_BIT] && !busy) |=> busy);

    p_oe_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> busy);

    p_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    p_high_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdc) |-> (hi_cnt == 16'(CLK_DIV)));

    p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> $stable(cmd_q));

    p_no_go_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !bus_wdata[CMD_GO_BIT] && !busy) |=> !busy);
endmodule

bind mdio_cmd_ctrl mdio_cmd_ctrl_chk #(.CLK_DIV(CLK_DIV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mdc       (mdc),
    .mdio_oe   (mdio_oe),
    .busy      (busy_w),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cmd_q     (cmd_w)
);

// File: tb/mdio_cmd_ctrl_bench.sv
module mdio_cmd_ctrl_bench;
    localparam int DIV = 4;
    localparam int NV  = 6;

    // vector: {wr, phy[4:0], reg[4:0], write value[15:0], PHY read value[15:0]}
    localparam logic [42:0] VEC [NV] = '{
        {1'b1, 5'h01, 5'h00, 16'h1140, 16'h0000},
        {1'b0, 5'h1F, 5'h1F, 16'h0000, 16'hA5C3},
        {1'b1, 5'h10, 5'h15, 16'h0000, 16'h0000},
        {1'b0, 5'h00, 5'h02, 16'h0000, 16'hFFFF},
        {1'b0, 5'h0A, 5'h11, 16'h0000, 16'h0001},
        {1'b1, 5'h15, 5'h0A, 16'h8001, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr, bus_rd;
    logic [1:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    always #4 clk = ~clk;

    mdio_cmd_ctrl #(.CLK_DIV(DIV)) u_mdio_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int          checks = 0;
    int          errors = 0;
    int          mon_cnt = 0;
    logic [63:0] cap_o, cap_oe;
    logic [15:0] phy_rval = '0;
    time         t_rise0, t_rise1;

    // PHY model: record at rising MDC, answer at falling MDC
    initial begin
        forever begin
            @(posedge mdc);
            if (mon_cnt < 64) begin
                cap_o[63-mon_cnt]  = mdio_o;
                cap_oe[63-mon_cnt] = mdio_oe;
            end
            if (mon_cnt == 0) t_rise0 = $time;
            if (mon_cnt == 1) t_rise1 = $time;
            mon_cnt++;
        end
    end

    initial begin
        mdio_i = 1'b1;
        forever begin
            @(negedge mdc);
            if (mon_cnt == 47)                      mdio_i = 1'b0;
            else if (mon_cnt >= 48 && mon_cnt < 64) mdio_i = phy_rval[63-mon_cnt];
            else                                    mdio_i = 1'b1;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic [31:0] mk_cmd(input logic go, input logic wr,
                                           input logic [4:0] phy, input logic [4:0] rg);
        logic [31:0] w = '0;
        w[0] = go; w[1] = wr; w[8:4] = rg; w[16:12] = phy;
        return w;
    endfunction

    function automatic logic [63:0] exp_frame(input logic wr, input logic [4:0] phy,
                                              input logic [4:0] rg, input logic [15:0] v);
        return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, 2'b10, v};
    endfunction

    task automatic wait_idle(output bit ok);
        logic [31:0] r;
        ok = 1'b0;
        for (int k = 0; k < 3000; k++) begin
            bus_read(2'd0, r);
            if (!r[0]) begin ok = 1'b1; break; end
        end
    endtask

    task automatic launch(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] rval);
        phy_rval = rval;
        mon_cnt  = 0;
        cap_o    = '0;
        cap_oe   = '0;
        bus_write(2'd0, mk_cmd(1'b1, wr, phy, rg));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        bit          ok;
        logic [63:0] mask;
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", "mdc", 64'(mdc), 64'd0);
        chk("R1", "mdio_oe", 64'(mdio_oe), 64'd0);
        rst_n = 1'b1;
        bus_read(2'd0, r); chk("R1", "command reg", 64'(r), 64'd0);
        bus_read(2'd1, r); chk("R1", "data reg", 64'(r), 64'd0);

        // vector table: both directions, edge-valued fields
        for (int i = 0; i < NV; i++) begin
            logic        wr;
            logic [4:0]  phy, rg;
            logic [15:0] wv, rv;
            {wr, phy, rg, wv, rv} = VEC[i];
            if (wr) bus_write(2'd1, {16'h0, wv});
            launch(wr, phy, rg, rv);
            bus_read(2'd0, r);
            chk("R2", "busy after launch", 64'(r[0]), 64'd1);
            wait_idle(ok);
            chk("R2", "busy cleared", 64'(ok), 64'd1);
            chk("R6", "rising MDC edges", 64'(mon_cnt), 64'd64);
            mask = wr ? '1 : {{46{1'b1}}, 18'h0};
            chk(wr ? "R4" : "R3", "frame bits", cap_o & mask,
                exp_frame(wr, phy, rg, wv) & mask);
            chk("R5", "output enable pattern", cap_oe, mask);
            bus_read(2'd0, r);
            chk("R2", "command readback", 64'(r), 64'(mk_cmd(1'b0, wr, phy, rg)));
            bus_read(2'd1, r);
            chk("R5", "data register", 64'(r), 64'(wr ? wv : rv));
        end

        // R6 MDC period and idle level
        chk("R6", "MDC period ns", 64'(t_rise1 - t_rise0), 64'(2 * DIV * 8));
        mon_cnt = 0;
        repeat (100) @(posedge clk);
        @(negedge clk);
        chk("R6", "mdc idle", 64'(mdc), 64'd0);
        chk("R6", "no edges while idle", 64'(mon_cnt), 64'd0);

        // R4 data sampled at launch
        bus_write(2'd1, 32'h0000_3C5A);
        launch(1'b1, 5'h03, 5'h04, 16'h0);
        repeat (60) @(posedge clk);
        bus_write(2'd1, 32'h0000_FFFF);
        wait_idle(ok);
        chk("R4", "frame keeps launch data", cap_o, exp_frame(1'b1, 5'h03, 5'h04, 16'h3C5A));

        // R7 command write while busy ignored
        launch(1'b0, 5'h01, 5'h07, 16'h1234);
        repeat (80) @(posedge clk);
        bus_write(2'd0, mk_cmd(1'b1, 1'b1, 5'h09, 5'h1E));
        bus_read(2'd0, r);
        chk("R7", "fields held while busy", 64'(r), 64'(mk_cmd(1'b1, 1'b0, 5'h01, 5'h07)));
        wait_idle(ok);
        repeat (600) @(posedge clk);
        @(negedge clk);
        chk("R7", "no second frame", 64'(mon_cnt), 64'd64);
        mask = {{46{1'b1}}, 18'h0};
        chk("R7", "frame from first command", cap_o & mask,
            exp_frame(1'b0, 5'h01, 5'h07, 16'h0) & mask);
        bus_read(2'd1, r);
        chk("R7", "read data of first command", 64'(r), 64'h1234);

        // R8 command without go bit
        mon_cnt = 0;
        bus_write(2'd0, mk_cmd(1'b0, 1'b1, 5'h12, 5'h05));
        repeat (100) @(posedge clk);
        bus_read(2'd0, r);
        chk("R8", "fields stored, not busy", 64'(r), 64'(mk_cmd(1'b0, 1'b1, 5'h12, 5'h05)));
        chk("R8", "no MDC edges", 64'(mon_cnt), 64'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule